// File: doc/BRIEF.md
# Paged Memory Load Buffer Controller

This block is the target-side staging buffer for paged programming of two non-volatile arrays. One is a word-wide program memory whose words arrive as separate low and high bytes. The other is a byte-wide data memory written in small pages. Load commands place bytes into the buffer at an offset taken from the low address bits. A write-page command then streams the staged entries to the array, into the page picked by the upper address bits. After that the staging state is wiped.

The upstream deserialiser has already framed each command. It presents one command per cycle as an opcode byte, an address and a data byte, qualified by a valid strobe. The block returns a busy flag and a commit stream to the array. The commit stream carries one write per cycle with a target select, a word or byte address, and data.

A low byte must come before the high byte of the same word. A high byte that breaks this rule is refused and raises a sticky error flag. A data-memory page commit touches only the bytes that were loaded. A program page commit writes every word of the page, and any byte that was not loaded is written as 0xFF, the erased value.

Top module: `plb_page_buffer`

## Requirements
- R1: Opcodes are decoded as follows: 0x40 loads a program low byte, 0x48 loads a program high byte, 0xC1 loads a data-memory byte, 0x4C commits a program page and 0xC2 commits a data-memory page. Any other opcode, and any cycle with cmd_valid low, changes nothing.
- R2: The offset of a program load is cmd_addr[5:0]. The page of a program commit is cmd_addr[12:6]. Each program commit write carries the word address {page, offset} on cm_addr.
- R3: A high-byte load is stored only if a low byte was loaded at the same offset since the last program commit. Otherwise it is discarded and order_err goes to 1. Once set, order_err stays at 1 until reset.
- R4: A program commit drives cm_we with cm_eep=0 for every offset 0 to 63 in rising order, one per cycle, starting two cycles after the command cycle. cm_data is {high, low}, and each byte that was not loaded reads 0xFF.
- R5: The offset of a data-memory load is cmd_addr[1:0] and the page of its commit is cmd_addr[7:2]. A data-memory commit drives cm_we with cm_eep=1 only for the offsets loaded since the last data-memory commit, in rising order. Each write sits in the cycle slot of its offset, with cm_addr={page, offset} and cm_data={8'h00, byte}.
- R6: busy rises one cycle after an accepted commit. It stays high for the number of page entries plus HOLD_CYC cycles (64+HOLD_CYC for program, 4+HOLD_CYC for data memory).
- R7: While busy is 1, every load and every commit command is ignored.
- R8: A commit clears the loaded marks of the buffer it wrote. A later program commit with no loads writes all 0xFFFF, and a later data-memory commit with no loads writes nothing.
- R9: After reset, busy, order_err and cm_we are 0 and no entry is marked loaded.
- R10: When the same byte position is loaded again before a commit, the latest data is committed. Reloading a low byte keeps the high byte that was already stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_code | input | 8 | Opcode byte |
| cmd_addr | input | 13 | Word address (program) or byte address (data memory) |
| cmd_data | input | 8 | Load data byte |
| busy | output | 1 | A commit is in progress |
| order_err | output | 1 | Sticky high-before-low error |
| cm_we | output | 1 | Commit write strobe to the array |
| cm_eep | output | 1 | Commit target: 1 data memory, 0 program memory |
| cm_addr | output | 13 | Commit address |
| cm_data | output | 16 | Commit data (data memory uses the low byte) |

## Verification
The assertions assume that at most one command arrives per cycle and that the inputs are steady around the rising edge. They also assume that the array accepts a commit write in every cycle, with no back-pressure. The bench drives every input on the falling edge and holds it for exactly one cycle. Its random phase mixes all five opcodes with unknown codes and with commands sent while busy. High bytes often arrive at offsets with no low byte, which exercises the refusal path.

// File: rtl/plb_pkg.sv
package plb_pkg;
  localparam logic [7:0] OPC_PLO = 8'h40;
  localparam logic [7:0] OPC_PHI = 8'h48;
  localparam logic [7:0] OPC_ELD = 8'hC1;
  localparam logic [7:0] OPC_PWR = 8'h4C;
  localparam logic [7:0] OPC_EWR = 8'hC2;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_PLO,
    OP_PHI,
    OP_ELD,
    OP_PWR,
    OP_EWR
  } plb_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SCAN,
    SQ_HOLD
  } plb_sq_e;
endpackage

// File: rtl/plb_decode.sv
module plb_decode
  import plb_pkg::*;
(
  input  logic       valid,
  input  logic [7:0] code,
  output plb_op_e    op
);
  // R1: only the five listed codes map to an operation
  always_comb begin
    op = OP_NONE;
    if (valid) begin
      case (code)
        OPC_PLO: op = OP_PLO;
        OPC_PHI: op = OP_PHI;
        OPC_ELD: op = OP_ELD;
        OPC_PWR: op = OP_PWR;
        OPC_EWR: op = OP_EWR;
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/plb_byte_ram.sv
module plb_byte_ram #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [7:0] mem [DEPTH];

  // simple dual-port shape with registered read, block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/plb_sequencer.sv
module plb_sequencer
  import plb_pkg::*;
#(
  parameter int OFS_W    = 6,
  parameter int EE_OFS_W = 2,
  parameter int PN_W     = 7,
  parameter int HOLD_CYC = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_ee,
  input  logic [PN_W-1:0]  start_page,
  output logic             busy,
  output logic             scan_act,
  output logic             scan_last,
  output logic [OFS_W-1:0] idx,
  output logic             kind_ee,
  output logic [PN_W-1:0]  page
);
  localparam int HC_W = $clog2(HOLD_CYC + 1);
  localparam logic [OFS_W-1:0] EE_LAST = OFS_W'((2 ** EE_OFS_W) - 1);
  localparam logic [HC_W-1:0]  H_LAST  = HC_W'(HOLD_CYC - 1);

  plb_sq_e         state;
  logic [HC_W-1:0] hcnt;
  logic [OFS_W-1:0] last_idx;

  assign last_idx  = kind_ee ? EE_LAST : '1;
  assign scan_act  = (state == SQ_SCAN);
  assign scan_last = scan_act && (idx == last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      busy    <= 1'b0;
      idx     <= '0;
      hcnt    <= '0;
      kind_ee <= 1'b0;
      page    <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          state   <= SQ_SCAN;
          busy    <= 1'b1;
          idx     <= '0;
          kind_ee <= start_ee;
          page    <= start_page;
        end
        SQ_SCAN: begin
          if (idx == last_idx) begin
            state <= SQ_HOLD;
            hcnt  <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        SQ_HOLD: begin
          if (hcnt == H_LAST) begin
            state <= SQ_IDLE;
            busy  <= 1'b0;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R6: busy only drops at the end of the hold phase
  p_busy_end_hold_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(state) == SQ_HOLD);

  // R7: a commit request during busy leaves the latched target untouched
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(kind_ee) && $stable(page)));
endmodule

// File: rtl/plb_page_buffer.sv
module plb_page_buffer
  import plb_pkg::*;
#(
  parameter int PG_OFS_W = 6,
  parameter int PG_NUM_W = 7,
  parameter int EE_OFS_W = 2,
  parameter int EE_NUM_W = 6,
  parameter int HOLD_CYC = 6,
  localparam int CA_W    = PG_OFS_W + PG_NUM_W,
  localparam int PG_N    = 2 ** PG_OFS_W,
  localparam int EE_N    = 2 ** EE_OFS_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [7:0]      cmd_code,
  input  logic [CA_W-1:0] cmd_addr,
  input  logic [7:0]      cmd_data,
  output logic            busy,
  output logic            order_err,
  output logic            cm_we,
  output logic            cm_eep,
  output logic [CA_W-1:0] cm_addr,
  output logic [15:0]     cm_data
);
  plb_op_e op;
  logic    ld_ok;
  logic    plo_we, phi_we, phi_bad, ee_we;
  logic    start_req;

  logic [PG_OFS_W-1:0] pofs;
  logic [EE_OFS_W-1:0] eofs;
  logic [PG_NUM_W-1:0] req_page;

  logic [PG_N-1:0] lo_mask, hi_mask;
  logic [EE_N-1:0] ee_mask;

  logic                scan_act, scan_last, kind_ee;
  logic [PG_OFS_W-1:0] idx;
  logic [PG_NUM_W-1:0] page;
  logic [7:0]          lo_rd, hi_rd, ee_rd;
  logic                lo_en_q, hi_en_q;
  logic [CA_W-1:0]     ee_cm_addr;

  plb_decode u_dec (
    .valid (cmd_valid),
    .code  (cmd_code),
    .op    (op)
  );

  // R2 / R5: offset and page fields of the command address
  assign pofs     = cmd_addr[PG_OFS_W-1:0];
  assign eofs     = cmd_addr[EE_OFS_W-1:0];
  assign req_page = (op == OP_EWR)
                  ? PG_NUM_W'(cmd_addr[EE_OFS_W +: EE_NUM_W])
                  : cmd_addr[PG_OFS_W +: PG_NUM_W];

  // R7: nothing is taken while a commit runs
  assign ld_ok     = !busy;
  assign plo_we    = ld_ok && (op == OP_PLO);
  assign phi_we    = ld_ok && (op == OP_PHI) && lo_mask[pofs];
  assign phi_bad   = ld_ok && (op == OP_PHI) && !lo_mask[pofs];
  assign ee_we     = ld_ok && (op == OP_ELD);
  assign start_req = (op == OP_PWR) || (op == OP_EWR);

  plb_sequencer #(
    .OFS_W    (PG_OFS_W),
    .EE_OFS_W (EE_OFS_W),
    .PN_W     (PG_NUM_W),
    .HOLD_CYC (HOLD_CYC)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start_req),
    .start_ee   (op == OP_EWR),
    .start_page (req_page),
    .busy       (busy),
    .scan_act   (scan_act),
    .scan_last  (scan_last),
    .idx        (idx),
    .kind_ee    (kind_ee),
    .page       (page)
  );

  plb_byte_ram #(.AW(PG_OFS_W)) u_lo_ram (
    .clk (clk), .we (plo_we), .waddr (pofs), .wdata (cmd_data),
    .raddr (idx), .rdata (lo_rd)
  );

  plb_byte_ram #(.AW(PG_OFS_W)) u_hi_ram (
    .clk (clk), .we (phi_we), .waddr (pofs), .wdata (cmd_data),
    .raddr (idx), .rdata (hi_rd)
  );

  plb_byte_ram #(.AW(EE_OFS_W)) u_ee_ram (
    .clk (clk), .we (ee_we), .waddr (eofs), .wdata (cmd_data),
    .raddr (idx[EE_OFS_W-1:0]), .rdata (ee_rd)
  );

  // loaded marks: set by loads, wiped at the last scan step (R8)
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_mask <= '0;
      hi_mask <= '0;
      ee_mask <= '0;
    end else begin
      if (scan_last && !kind_ee) begin
        lo_mask <= '0;
        hi_mask <= '0;
      end else begin
        if (plo_we) lo_mask[pofs] <= 1'b1;
        if (phi_we) hi_mask[pofs] <= 1'b1;
      end
      if (scan_last && kind_ee) ee_mask <= '0;
      else if (ee_we)           ee_mask[eofs] <= 1'b1;
    end
  end

  // R3: sticky order error
  always_ff @(posedge clk) begin
    if (rst)          order_err <= 1'b0;
    else if (phi_bad) order_err <= 1'b1;
  end

  assign ee_cm_addr = CA_W'({page[EE_NUM_W-1:0], idx[EE_OFS_W-1:0]});

  // commit stream, aligned with the registered RAM reads (R4 / R5)
  always_ff @(posedge clk) begin
    if (rst) begin
      cm_we   <= 1'b0;
      cm_eep  <= 1'b0;
      cm_addr <= '0;
      lo_en_q <= 1'b0;
      hi_en_q <= 1'b0;
    end else begin
      cm_we   <= scan_act && (kind_ee ? ee_mask[idx[EE_OFS_W-1:0]] : 1'b1);
      cm_eep  <= kind_ee;
      cm_addr <= kind_ee ? ee_cm_addr : {page, idx};
      lo_en_q <= lo_mask[idx];
      hi_en_q <= hi_mask[idx];
    end
  end

  assign cm_data = cm_eep ? {8'h00, ee_rd}
                          : {hi_en_q ? hi_rd : 8'hFF, lo_en_q ? lo_rd : 8'hFF};

  // R4: array writes only happen inside a busy window
  p_we_in_busy_r4: assert property (@(posedge clk) disable iff (rst)
    cm_we |-> busy);

  // R3: error flag never clears without reset
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    order_err |=> order_err);

  // R3: a high byte is never marked without its low byte
  p_hi_after_lo_r3: assert property (@(posedge clk) disable iff (rst)
    (hi_mask & ~lo_mask) == '0);

  // R8: program marks are empty after the program scan ends
  p_clear_after_commit_r8: assert property (@(posedge clk) disable iff (rst)
    (scan_last && !kind_ee) |=> (lo_mask == '0 && hi_mask == '0));

  // R7: loads during busy leave the data-memory marks alone
  p_busy_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !scan_last) |=> $stable(ee_mask));
endmodule

// File: tb/tb_plb_page_buffer.sv
module tb_plb_page_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 6;

  typedef struct {
    bit          busy;
    bit          we;
    bit          eep;
    logic [12:0] addr;
    logic [15:0] data;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic [12:0] cmd_addr = '0;
  logic [7:0]  cmd_data = 8'h00;
  logic        busy, order_err, cm_we, cm_eep;
  logic [12:0] cm_addr;
  logic [15:0] cm_data;

  int n_vec = 0;
  int n_bad = 0;
  bit checking = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  plb_page_buffer #(.HOLD_CYC(HOLD)) dut (
    .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_code (cmd_code),
    .cmd_addr (cmd_addr), .cmd_data (cmd_data), .busy (busy),
    .order_err (order_err), .cm_we (cm_we), .cm_eep (cm_eep),
    .cm_addr (cm_addr), .cm_data (cm_data)
  );

  // behavioural reference
  logic [7:0] m_lo [64];
  logic [7:0] m_hi [64];
  bit         m_lov [64];
  bit         m_hiv [64];
  logic [7:0] m_ee [4];
  bit         m_eev [4];
  bit         m_err;
  exp_t       q [$];
  exp_t       cur;

  function automatic exp_t idle_e();
    exp_t e;
    e.busy = 0; e.we = 0; e.eep = 0; e.addr = '0; e.data = '0;
    return e;
  endfunction

  function automatic exp_t mk(bit we, bit eep, logic [12:0] a, logic [15:0] d);
    exp_t e;
    e.busy = 1; e.we = we; e.eep = eep; e.addr = a; e.data = d;
    return e;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) begin m_lov[i] = 0; m_hiv[i] = 0; end
      for (int i = 0; i < 4; i++) m_eev[i] = 0;
      m_err = 0;
      q.delete();
      cur = idle_e();
    end else begin
      if (!cur.busy && cmd_valid) begin
        case (cmd_code)
          8'h40: begin m_lo[cmd_addr[5:0]] = cmd_data; m_lov[cmd_addr[5:0]] = 1; end
          8'h48: begin
            if (m_lov[cmd_addr[5:0]]) begin
              m_hi[cmd_addr[5:0]] = cmd_data; m_hiv[cmd_addr[5:0]] = 1;
            end else m_err = 1;
          end
          8'hC1: begin m_ee[cmd_addr[1:0]] = cmd_data; m_eev[cmd_addr[1:0]] = 1; end
          8'h4C: begin
            q.push_back(mk(0, 0, '0, '0));
            for (int i = 0; i < 64; i++) begin
              q.push_back(mk(1, 0, {cmd_addr[12:6], 6'(i)},
                {m_hiv[i] ? m_hi[i] : 8'hFF, m_lov[i] ? m_lo[i] : 8'hFF}));
              m_lov[i] = 0; m_hiv[i] = 0;
            end
            for (int i = 0; i < HOLD - 1; i++) q.push_back(mk(0, 0, '0, '0));
          end
          8'hC2: begin
            q.push_back(mk(0, 0, '0, '0));
            for (int i = 0; i < 4; i++) begin
              q.push_back(mk(m_eev[i], 1, {5'd0, cmd_addr[7:2], 2'(i)},
                {8'h00, m_ee[i]}));
              m_eev[i] = 0;
            end
            for (int i = 0; i < HOLD - 1; i++) q.push_back(mk(0, 0, '0, '0));
          end
          default: ;
        endcase
      end
      if (q.size() > 0) cur = q.pop_front();
      else              cur = idle_e();
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (checking && !rst) begin
      n_vec++;
      if (busy !== cur.busy) begin
        n_bad++;
        $display("FAIL R6 busy act=%b exp=%b t=%0t", busy, cur.busy, $time);
      end
      if (order_err !== m_err) begin
        n_bad++;
        $display("FAIL R3 order_err act=%b exp=%b t=%0t", order_err, m_err, $time);
      end
      if (cm_we !== cur.we) begin
        n_bad++;
        $display("FAIL %s cm_we act=%b exp=%b t=%0t", cur.eep ? "R5" : "R4",
                 cm_we, cur.we, $time);
      end else if (cur.we && (cm_eep !== cur.eep || cm_addr !== cur.addr
                              || cm_data !== cur.data)) begin
        n_bad++;
        $display("FAIL %s commit act=%b/%h/%h exp=%b/%h/%h t=%0t",
                 cur.eep ? "R5" : "R2/R4", cm_eep, cm_addr, cm_data,
                 cur.eep, cur.addr, cur.data, $time);
      end
    end
  end

  task automatic send(input logic [7:0] c, input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state at the ports
    n_vec++;
    if (busy !== 1'b0 || order_err !== 1'b0 || cm_we !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 reset act=%b%b%b exp=000", busy, order_err, cm_we);
    end
    checking = 1'b1;

    // R1: unknown opcodes do nothing; R8/R9: empty buffer commits all FF
    send(8'h20, 13'h0011, 8'h5A);
    send(8'hAC, 13'h0012, 8'h33);
    send(8'h4C, 13'h0040, 8'h00);
    settle();

    // R2/R4/R10: mixed loads, reloads, then program commit on page 0x55
    send(8'h40, 13'h0003, 8'h11);
    send(8'h48, 13'h0003, 8'h22);
    send(8'h40, 13'h0003, 8'h44);   // R10: new low, high kept
    send(8'h40, 13'h003F, 8'h9C);
    send(8'h40, 13'h0000, 8'h01);
    send(8'h48, 13'h0000, 8'h02);
    send(8'h48, 13'h0000, 8'h07);   // R10: latest high wins
    send(8'h4C, {7'h55, 6'h00}, 8'h00);
    // R7: loads and commits while busy are dropped
    send(8'h40, 13'h0005, 8'hEE);
    send(8'hC1, 13'h0001, 8'hEE);
    send(8'hC2, 13'h0008, 8'h00);
    settle();

    // R3: high byte with no low byte is refused, flag stays
    send(8'h48, 13'h0009, 8'hAB);
    send(8'h40, 13'h0009, 8'hCD);
    send(8'h4C, {7'h7F, 6'h00}, 8'h00);
    settle();

    // R5: data-memory page with a partial load
    send(8'hC1, 13'h0002, 8'h77);
    send(8'hC1, 13'h0000, 8'h66);
    send(8'hC1, 13'h0002, 8'h78);   // R10: reload
    send(8'hC2, 13'h00A8, 8'h00);
    settle();
    // R8: nothing loaded, no data-memory writes
    send(8'hC2, 13'h00FC, 8'h00);
    settle();

    // random mix of every code, back to back, including during busy
    for (int k = 0; k < 6000; k++) begin
      int r;
      @(negedge clk);
      r = $urandom_range(0, 99);
      cmd_valid = ($urandom_range(0, 9) != 0);
      cmd_addr  = 13'($urandom);
      cmd_data  = 8'($urandom);
      if      (r < 30) cmd_code = 8'h40;
      else if (r < 55) cmd_code = 8'h48;
      else if (r < 80) cmd_code = 8'hC1;
      else if (r < 83) cmd_code = 8'h4C;
      else if (r < 88) cmd_code = 8'hC2;
      else             cmd_code = 8'($urandom);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    settle();
    finish_run();
  end
endmodule